// File: doc/BRIEF.md
# Pseudo-Random Noise Bit Generator

This block is a maximal-length linear feedback shift register that delivers one pseudo-random bit per enabled clock. It is meant as a cheap white-noise source. The polarity of the feedback is fixed when the block is built. Either XOR feedback or XNOR feedback can be chosen. Each polarity has one state from which the register can never leave. For XOR that state is all zeros. For XNOR it is all ones.

The register's power-up contents are never trusted. A synchronous reset writes a default seed that is legal for the chosen polarity. A user seed can also be loaded at any time. A guard keeps the forbidden state out of the register. If a loaded seed, or the value the register holds, equals the forbidden state, the guard writes the default seed in its place. It then raises a one-cycle recovery flag. The serial noise output is the top bit of the register, and the whole register is also visible as a parallel word.

Top module: `lfsr_noise`

## Requirements
- R1: A synchronous reset writes the default seed and clears the recovery flag on the next edge. The default seed is all ones for XOR feedback and all zeros for XNOR feedback. Reset takes priority over load and enable.
- R2: With reset, load and enable all low, the state word keeps its value.
- R3: With enable high and no load, each edge shifts the state one place toward the top. The new bit 0 is the XOR of state bits 15, 14, 12 and 3 (the taps 16, 15, 13 and 4 of a 16-stage register). With XNOR feedback this new bit is inverted.
- R4: From reset onward, the state never equals the forbidden value: all zeros for XOR, all ones for XNOR.
- R5: A load whose seed is legal writes that seed on the next edge. Load takes priority over enable, so no step happens in that cycle.
- R6: If the value about to be written equals the forbidden state, the default seed is written instead. This value is either a loaded seed or the value the register holds.
- R7: The recovery flag is high in exactly the cycle after each override of R6, and low otherwise.
- R8: The serial noise bit always equals the top bit of the state word.
- R9: After reset with enable held high, the state first returns to the default seed after exactly 2^16-1 = 65535 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| load | input | 1 | Seed load request |
| seed_in | input | W | Seed value used on load |
| noise_bit | output | 1 | Serial noise output (state top bit) |
| state_q | output | W | Parallel state word |
| recover | output | 1 | One-cycle pulse after a guard override |

## Verification
Two functions can fall in the same cycle: a seed load and the lockup guard. A load of the forbidden value can also arrive together with a high enable. The bench provokes this by loading all zeros and all ones while enable is high. One instance uses XOR feedback and the other uses XNOR feedback, so the same word is forbidden for one instance and legal for the other. The bench judges the next cycle against a behavioural model. For the instance where the word is forbidden, it expects the default seed with the flag high and no step. For the other instance, it expects the loaded word with the flag low.

// File: rtl/lfsr_noise.sv
module lfsr_noise #(
  parameter int             W       = 16,
  parameter logic [W-1:0]   TAPS    = 16'hD008,
  parameter bit             XNOR_FB = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] seed_in,
  output logic         noise_bit,
  output logic [W-1:0] state_q,
  output logic         recover
);

  localparam logic [W-1:0] LOCKUP  = XNOR_FB ? {W{1'b1}} : {W{1'b0}};
  localparam logic [W-1:0] DEFSEED = ~LOCKUP;

  logic [W-1:0] st;
  logic         flag;
  logic         fb;

  assign fb        = (^(st & TAPS)) ^ XNOR_FB;
  assign noise_bit = st[W-1];
  assign state_q   = st;
  assign recover   = flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= DEFSEED;
      flag <= 1'b0;
    end else begin
      flag <= 1'b0;
      if (load) begin
        if (seed_in == LOCKUP) begin
          st   <= DEFSEED;
          flag <= 1'b1;
        end else begin
          st <= seed_in;
        end
      end else if (st == LOCKUP) begin
        st   <= DEFSEED;
        flag <= 1'b1;
      end else if (en) begin
        st <= {st[W-2:0], fb};
      end
    end
  end

endmodule

module lfsr_noise_chk #(
  parameter int             W       = 16,
  parameter logic [W-1:0]   TAPS    = 16'hD008,
  parameter bit             XNOR_FB = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         load,
  input logic [W-1:0] seed_in,
  input logic         noise_bit,
  input logic [W-1:0] state_q,
  input logic         recover
);

  localparam logic [W-1:0] LOCKUP  = XNOR_FB ? {W{1'b1}} : {W{1'b0}};
  localparam logic [W-1:0] DEFSEED = ~LOCKUP;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  a_r1_reset_seed: assert property (@(posedge clk)
    rst |=> (state_q == DEFSEED && !recover));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    (!en && !load && state_q != LOCKUP) |=> $stable(state_q));

  a_r3_step: assert property (@(posedge clk) disable iff (rst || !armed)
    (en && !load && state_q != LOCKUP) |=>
      state_q == {$past(state_q[W-2:0]), (^($past(state_q) & TAPS)) ^ XNOR_FB});

  a_r4_never_lockup: assert property (@(posedge clk) disable iff (rst || !armed)
    state_q != LOCKUP);

  a_r5_load: assert property (@(posedge clk) disable iff (rst || !armed)
    (load && seed_in != LOCKUP) |=> state_q == $past(seed_in));

  a_r6_bad_load: assert property (@(posedge clk) disable iff (rst || !armed)
    (load && seed_in == LOCKUP) |=> (state_q == DEFSEED && recover));

  a_r7_flag_cause: assert property (@(posedge clk) disable iff (rst || !armed)
    recover |-> ($past(load && seed_in == LOCKUP) || $past(!load && state_q == LOCKUP)));

  a_r7_flag_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
    (!load && state_q != LOCKUP) |=> !recover);

  a_r8_serial: assert property (@(posedge clk) disable iff (rst || !armed)
    noise_bit == state_q[W-1]);

endmodule

bind lfsr_noise lfsr_noise_chk #(.W(W), .TAPS(TAPS), .XNOR_FB(XNOR_FB)) u_chk (.*);

// File: tb/test_lfsr_noise.sv
`timescale 1ns/1ps
module test_lfsr_noise;
  localparam int TP [4] = '{16, 15, 13, 4};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, en = 1'b0, load = 1'b0;
  logic [15:0] seed = 16'h0;
  logic        nb_x, nb_n, rc_x, rc_n;
  logic [15:0] st_x, st_n;

  lfsr_noise #(.W(16), .TAPS(16'hD008), .XNOR_FB(1'b0)) i_lfsr_noise (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed_in(seed),
    .noise_bit(nb_x), .state_q(st_x), .recover(rc_x));

  lfsr_noise #(.W(16), .TAPS(16'hD008), .XNOR_FB(1'b1)) i_lfsr_noise_xnor (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed_in(seed),
    .noise_bit(nb_n), .state_q(st_n), .recover(rc_n));

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;
  string tag = "R3";

  task automatic chk(input bit ok, input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic logic [16:0] model_next(input logic [15:0] s, input bit xn);
    logic [15:0] bad, dflt;
    logic b;
    bad  = xn ? 16'hFFFF : 16'h0000;
    dflt = ~bad;
    if (rst) return {1'b0, dflt};
    if (load) return (seed == bad) ? {1'b1, dflt} : {1'b0, seed};
    if (!en) return {1'b0, s};
    b = xn;
    foreach (TP[i]) b ^= s[TP[i]-1];
    return {1'b0, s[14:0], b};
  endfunction

  logic [15:0] mx = 16'h0, mn = 16'h0;
  logic        mrx = 1'b0, mrn = 1'b0;
  always @(posedge clk) begin
    {mrx, mx} <= model_next(mx, 1'b0);
    {mrn, mn} <= model_next(mn, 1'b1);
  end

  always @(negedge clk) if (cmp_on) begin
    chk(st_x == mx, {tag, " xor state"}, st_x, mx);
    chk(st_n == mn, {tag, " xnor state"}, st_n, mn);
    chk(rc_x == mrx, {"R7 xor flag ", tag}, {15'b0, rc_x}, {15'b0, mrx});
    chk(rc_n == mrn, {"R7 xnor flag ", tag}, {15'b0, rc_n}, {15'b0, mrn});
    chk(nb_x == st_x[15] && nb_n == st_n[15], "R8 serial bit", {14'b0, nb_x, nb_n}, {14'b0, st_x[15], st_n[15]});
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first_x, first_n;
    bit seen_bad;
    cyc(2);
    chk(st_x == 16'hFFFF && !rc_x, "R1 xor reset seed", st_x, 16'hFFFF);
    chk(st_n == 16'h0000 && !rc_n, "R1 xnor reset seed", st_n, 16'h0000);
    cmp_on = 1'b1;

    tag = "R3 free run"; rst = 1'b0; en = 1'b1; cyc(100);

    tag = "R2 gated";
    for (int i = 0; i < 60; i++) begin en = (i % 3 == 0); cyc(1); end
    en = 1'b0; cyc(1);
    chk(st_x == mx, "R2 hold xor", st_x, mx);

    tag = "R5 load over enable"; en = 1'b1; load = 1'b1; seed = 16'h1234; cyc(1);
    load = 1'b0;
    chk(st_x == 16'h1234 && st_n == 16'h1234, "R5 seed loaded, no step", st_x, 16'h1234);
    cyc(20);

    tag = "R6 zero load"; load = 1'b1; seed = 16'h0000; cyc(1);
    load = 1'b0;
    chk(st_x == 16'hFFFF && rc_x, "R6 xor zero seed replaced", st_x, 16'hFFFF);
    chk(st_n == 16'h0000 && !rc_n, "R6 xnor zero seed kept", st_n, 16'h0000);
    cyc(1);
    chk(!rc_x, "R7 xor flag one cycle", {15'b0, rc_x}, 16'h0);
    cyc(10);

    tag = "R6 ones load twice"; load = 1'b1; seed = 16'hFFFF; cyc(2);
    load = 1'b0;
    chk(st_n == 16'h0000 && rc_n, "R6 xnor ones seed replaced", st_n, 16'h0000);
    chk(st_x == 16'hFFFF && !rc_x, "R6 xor ones seed kept", st_x, 16'hFFFF);
    cyc(10);

    tag = "R5 mixed seed"; load = 1'b1; seed = 16'h00FF; cyc(1); load = 1'b0; cyc(30);

    tag = "R1 reset wins"; rst = 1'b1; load = 1'b1; seed = 16'h5A5A; cyc(1);
    chk(st_x == 16'hFFFF && st_n == 16'h0000, "R1 reset beats load", st_x, 16'hFFFF);
    load = 1'b0;

    tag = "R9 period"; rst = 1'b0; en = 1'b1;
    first_x = 0; first_n = 0; seen_bad = 1'b0;
    for (int k = 1; k <= 65535; k++) begin
      cyc(1);
      if (st_x == 16'h0000 || st_n == 16'hFFFF) seen_bad = 1'b1;
      if (first_x == 0 && st_x == 16'hFFFF) first_x = k;
      if (first_n == 0 && st_n == 16'h0000) first_n = k;
    end
    chk(!seen_bad, "R4 lockup state never reached", {15'b0, seen_bad}, 16'h0);
    chk(first_x == 65535, "R9 xor period", first_x[15:0], 16'hFFFF);
    chk(first_n == 65535, "R9 xnor period", first_n[15:0], 16'hFFFF);

    cmp_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule